// File: doc/BRIEF.md
# DMA Channel Event Interrupt Collector

This block gathers completion events from a set of DMA channel engines and turns them into one processor interrupt line. Every channel owns a four-bit slot that records three kinds of event: a half-package mark, a package-done mark and a queue-done mark. Events are latched as pending bits. Software reads and writes them through a plain register port that also holds a matching set of enable bits.

The interrupt line is the registered OR of every pending bit that has its enable bit set. Pending bits are recorded whether or not they are enabled. Software acknowledges events by writing the value it read back into the pending word. A one clears its bit and a zero leaves it alone. When a new event and a clear hit the same bit in the same cycle, the event wins.

Top module: `dma_irq_agg`

## Requirements
- R1: Channel n maps to word n/8 at bit offset (n mod 8)*4. Within its slot, bit 0 is half-package, bit 1 is package-done and bit 2 is queue-done.
- R2: Enable word k is at byte address 4*k and pending word k is at 0x10 + 4*k, for k = 0 and 1. Any other address reads zero, and writes to it change nothing.
- R3: An event pulse sets its pending bit on the next clock edge, whatever the enable bits hold.
- R4: Writing to a pending word clears each bit written as one and leaves each bit written as zero unchanged.
- R5: An event arriving in the same cycle as a write-one-to-clear of the same bit leaves that bit set.
- R6: `irq_o` rises one cycle after a pending bit and its enable bit are both set. It falls one cycle after the last such pair is broken.
- R7: With both enable words at zero, `irq_o` stays low whatever is pending.
- R8: Bit 3 of every slot reads zero in both banks, and writes to it have no effect.
- R9: After reset, every enable and pending bit is zero and `irq_o` is low.
- R10: An enable word holds the value last written to it (with bit 3 of each slot masked) until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| evt_half | input | NUM_CH | Half-package event pulse per channel |
| evt_pkg | input | NUM_CH | Package-done event pulse per channel |
| evt_queue | input | NUM_CH | Queue-done event pulse per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The bench sets an event and a clear on the same bit in one cycle. A design that lets the clear win would lose that event. It writes all ones into enable and pending words and expects bit 3 of every slot to read zero; a design that stores it would show an 8 in some nibble. It writes to an unmapped address between the two banks and checks that neither bank changed, which catches sloppy decoding. It also counts the exact cycles from an enabled event, or from its clear, to the edge on `irq_o`, which exposes a line that is combinational or delayed by an extra cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int SLOT_W      = 4;
  localparam int CH_PER_WORD = 8;
  localparam int WORD_W      = SLOT_W * CH_PER_WORD;
  localparam int EV_HALF     = 0;
  localparam int EV_PKG      = 1;
  localparam int EV_QUEUE    = 2;

  // bits that hold state: the three event positions of every slot
  function automatic logic [WORD_W-1:0] live_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < CH_PER_WORD; s++) begin
      m[s*SLOT_W + EV_HALF]  = 1'b1;
      m[s*SLOT_W + EV_PKG]   = 1'b1;
      m[s*SLOT_W + EV_QUEUE] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_irq_en_bank.sv
module dma_irq_en_bank
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q
);
  localparam logic [WORD_W-1:0] MASK = live_mask();

  logic [WORD_W-1:0] en_nxt;

  always_comb begin
    en_nxt = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= en_nxt;
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_q)); // R10
endmodule

// File: rtl/dma_irq_pend_bank.sv
module dma_irq_pend_bank
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_hit,
  input  logic [WORD_W-1:0] clr_data,
  input  logic [WORD_W-1:0] evt,
  output logic [WORD_W-1:0] pend_q
);
  localparam logic [WORD_W-1:0] MASK = live_mask();

  logic [WORD_W-1:0] clr_vec;
  logic [WORD_W-1:0] pend_nxt;
  logic              pend_ce;

  always_comb begin
    clr_vec  = clr_hit ? clr_data : '0;
    // set after clear: a fresh event survives a same-cycle acknowledge
    pend_nxt = ((pend_q & ~clr_vec) | evt) & MASK;
    pend_ce  = clr_hit | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_nxt;
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & MASK) != '0) |=> ((pend_q & $past(evt & MASK)) == $past(evt & MASK))); // R5
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && evt == '0) |=> $stable(pend_q)); // R4
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int                NUM_CH    = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] PEND_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkg,
  input  logic [NUM_CH-1:0] evt_queue,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  localparam int NWORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
  localparam int NSLOTS = NWORDS * CH_PER_WORD;

  logic [NWORDS-1:0][WORD_W-1:0] en_w;
  logic [NWORDS-1:0][WORD_W-1:0] pend_w;
  logic [NWORDS-1:0][WORD_W-1:0] evt_w;
  logic [NWORDS-1:0]             en_sel;
  logic [NWORDS-1:0]             pend_sel;
  logic [NSLOTS*SLOT_W-1:0]      evt_flat;
  logic                          irq_nxt;

  // scatter the per-channel event lines into slot positions
  genvar n;
  generate
    for (n = 0; n < NSLOTS; n++) begin : g_slot
      if (n < NUM_CH) begin : g_live
        assign evt_flat[n*SLOT_W +: SLOT_W] = {1'b0, evt_queue[n], evt_pkg[n], evt_half[n]};
      end else begin : g_pad
        assign evt_flat[n*SLOT_W +: SLOT_W] = '0;
      end
    end
  endgenerate

  genvar k;
  generate
    for (k = 0; k < NWORDS; k++) begin : g_word
      localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(4 * k);
      localparam logic [ADDR_W-1:0] PD_ADDR = PEND_BASE + ADDR_W'(4 * k);

      assign evt_w[k]    = evt_flat[k*WORD_W +: WORD_W];
      assign en_sel[k]   = reg_wr && (reg_addr == EN_ADDR);
      assign pend_sel[k] = reg_wr && (reg_addr == PD_ADDR);

      dma_irq_en_bank u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (en_sel[k]),
        .wdata  (reg_wdata),
        .en_q   (en_w[k])
      );

      dma_irq_pend_bank u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_hit  (pend_sel[k]),
        .clr_data (reg_wdata),
        .evt      (evt_w[k]),
        .pend_q   (pend_w[k])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (reg_addr == ADDR_W'(4 * i))           reg_rdata = en_w[i];
      if (reg_addr == PEND_BASE + ADDR_W'(4 * i)) reg_rdata = pend_w[i];
    end
  end

  always_comb begin
    irq_nxt = 1'b0;
    for (int i = 0; i < NWORDS; i++) irq_nxt = irq_nxt | (|(pend_w[i] & en_w[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_nxt;
  end

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nxt |=> irq_o); // R6
  AST_IRQ_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w == '0 && $past(en_w) == '0) |-> !irq_o); // R7
  AST_SPARE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~live_mask()) == '0); // R8
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && en_sel == '0) |=> $stable(en_w)); // R2
endmodule

// File: tb/dma_irq_agg_test.sv
`timescale 1ns/100ps
module dma_irq_agg_test;
  localparam int NCH = 16;
  localparam logic [31:0] LIVE = 32'h7777_7777;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NCH-1:0] evt_half, evt_pkg, evt_queue;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_en [2];
  logic [31:0] m_pend [2];
  logic        m_irq;

  always #2.5 clk = ~clk;

  dma_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_pkg(evt_pkg),
    .evt_queue(evt_queue), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // R1 slot layout: channel n in word n/8, bits (n%8)*4 + {0,1,2}
  function automatic logic [31:0] pack_word(int k, logic [NCH-1:0] h,
                                            logic [NCH-1:0] p, logic [NCH-1:0] q);
    logic [31:0] w = '0;
    for (int s = 0; s < 8; s++) begin
      w[s*4+0] = h[k*8+s];
      w[s*4+1] = p[k*8+s];
      w[s*4+2] = q[k*8+s];
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    for (int k = 0; k < 2; k++) begin
      if (a == 8'(4*k))        return m_en[k];
      if (a == 8'(16 + 4*k))   return m_pend[k];
    end
    return 32'h0;
  endfunction

  // reference model, updated from the stimulus the bench itself drives
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq <= 1'b0;
      for (int k = 0; k < 2; k++) begin m_en[k] <= '0; m_pend[k] <= '0; end
    end else begin
      m_irq <= |((m_pend[0] & m_en[0]) | (m_pend[1] & m_en[1]));
      for (int k = 0; k < 2; k++) begin
        logic [31:0] clr;
        clr = (reg_wr && reg_addr == 8'(16 + 4*k)) ? reg_wdata : 32'h0;
        if (reg_wr && reg_addr == 8'(4*k)) m_en[k] <= reg_wdata & LIVE;
        m_pend[k] <= ((m_pend[k] & ~clr) | pack_word(k, evt_half, evt_pkg, evt_queue)) & LIVE;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  // at a falling edge: compare everything, then drive the next cycle
  task automatic step(logic wr, logic [7:0] a, logic [31:0] d,
                      logic [NCH-1:0] h, logic [NCH-1:0] p, logic [NCH-1:0] q);
    logic [31:0] v;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 irq_o", {31'b0, irq_o}, {31'b0, m_irq});
    foreach (m_en[k]) begin
      rd(8'(4*k), v);      chk("R10 enable read", v, m_en[k]);
      rd(8'(16 + 4*k), v); chk("R3 pending read", v, m_pend[k]);
    end
    rd(8'h08, v); chk("R2 unmapped read", v, 32'h0);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    evt_half = h; evt_pkg = p; evt_queue = q;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h0, 32'h0, '0, '0, '0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_half = '0; evt_pkg = '0; evt_queue = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset state
    chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);
    for (int k = 0; k < 2; k++) begin
      rd(8'(4*k), v);    chk("R9 enable reset", v, 32'h0);
      rd(8'(16+4*k), v); chk("R9 pending reset", v, 32'h0);
    end

    // R1 / R3: channel 11 package-done lands at word 1 bit 13, enable off
    step(1'b0, 8'h0, 0, '0, 16'h0800, '0);
    idle(2);
    @(negedge clk);
    rd(8'h14, v); chk("R1 ch11 pkg slot", v, 32'h0000_2000);
    rd(8'h10, v); chk("R1 word0 untouched", v, 32'h0);
    chk("R3 pending w/o enable, irq low", {31'b0, irq_o}, 32'h0);

    // R8 / R10: all-ones into enable word 1
    step(1'b1, 8'h04, 32'hFFFF_FFFF, '0, '0, '0);
    @(negedge clk); reg_wr = 1'b0;
    rd(8'h04, v); chk("R8 spare bits of enable", v, LIVE);
    chk("R6 irq one cycle after enable", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R6 irq rises", {31'b0, irq_o}, 32'h1);

    // R4: writing zeros clears nothing, writing the bit clears it
    step(1'b1, 8'h14, 32'h0, '0, '0, '0);
    step(1'b1, 8'h14, 32'h0000_2000, '0, '0, '0);
    @(negedge clk); reg_wr = 1'b0;
    rd(8'h14, v); chk("R4 write-one clears", v, 32'h0);
    chk("R6 irq still high one cycle", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R6 irq falls", {31'b0, irq_o}, 32'h0);

    // R5: channel 3 half event together with its clear
    step(1'b1, 8'h10, 32'h0000_1000, 16'h0008, '0, '0);
    @(negedge clk); reg_wr = 1'b0; evt_half = '0;
    rd(8'h10, v); chk("R5 event beats clear", v, 32'h0000_1000);

    // R8: bit 3 written into pending cannot appear; R2 stray write
    step(1'b1, 8'h0C, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    @(negedge clk); reg_wr = 1'b0; evt_half = '0; evt_pkg = '0; evt_queue = '0;
    rd(8'h10, v); chk("R8 spare pending bits", v, LIVE);
    rd(8'h00, v); chk("R2 stray write leaves enable0", v, 32'h0);

    // R7: both enables zero, everything pending
    step(1'b1, 8'h00, 32'h0, '0, '0, '0);
    step(1'b1, 8'h04, 32'h0, '0, '0, '0);
    idle(2);
    @(negedge clk);
    chk("R7 no enables, irq low", {31'b0, irq_o}, 32'h0);

    // randomized phase against the model
    for (int i = 0; i < 800; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [NCH-1:0] h, p, q;
      case ($urandom % 6)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10; 3: a = 8'h14;
        4: a = 8'h08; default: a = 8'($urandom % 32);
      endcase
      d = $urandom;
      if ($urandom % 2) d = d & $urandom;
      h = 16'(1 << ($urandom % 16)) & {16{($urandom % 4) == 0}};
      p = 16'(1 << ($urandom % 16)) & {16{($urandom % 5) == 0}};
      q = 16'(1 << ($urandom % 16)) & {16{($urandom % 7) == 0}};
      step(($urandom % 3) == 0, a, d, h, p, q);
    end
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule